// File: doc/BRIEF.md
# Memory Region Access Guard

This block stands between one bus request port and a small group of on-chip memory targets. Each request carries an address, an access size, a burst flag and a write flag. The guard decodes the address into one of a fixed set of windows. It then checks the access against that window's rules and against live system state: the data cache enable, the program cache enable and the on-chip debug enable. If every rule holds, the request is forwarded to exactly one target and the guard reports whether that window is a cacheable view. If any rule fails, no target is selected, and a bus error pulse follows one cycle later.

The verdict is combinational in the request cycle, so the interconnect can steer the request at once. Only the error response is registered. Program flash and the shared local memory each appear through two windows, one cacheable and one not. Both windows of a pair select the same target and differ only in the cacheable output. Writes that land in any flash window are sent to the flash command handler instead of the flash read port.

Top module: `mem_region_guard`

## Requirements
- R1: Windows (base, size): 0x7000_0000/64 KiB data scratchpad; 0x7010_0000/64 KiB program scratchpad; 0x7020_0000/16 KiB data cache array; 0x7030_0000/4 KiB data tag array; 0x7040_0000/16 KiB program cache array; 0x7050_0000/4 KiB program tag array; 0x8000_0000/16 MiB cached program flash; 0xA000_0000/16 MiB uncached program flash; 0xAF00_0000/16 MiB uncached data flash; 0x9000_0000/1 MiB cached local memory; 0xB000_0000/1 MiB uncached local memory; 0xF000_0000/4 KiB trace RAM. Any address outside all windows is rejected.
- R2: The data cache array and data tag array windows reject every access while `dcache_en` is 1.
- R3: The program cache array and program tag array windows reject every access while `pcache_en` is 1.
- R4: Both tag array windows reject any burst access and any access whose address bits [2:0] are not zero.
- R5: `req_size` is encoded 0 = byte, 1 = half-word, 2 = word, 3 = double-word. An access whose address is not a multiple of its size is rejected in every window.
- R6: The trace RAM window rejects every access while `dbg_en` is 0.
- R7: The scratchpad windows accept every size, single or burst, read or write, when aligned.
- R8: Target select bits: bit 0 CPU-local RAM (scratchpad, cache and tag windows), bit 1 flash read port, bit 2 local memory, bit 3 trace RAM, bit 4 flash command handler. Both views of program flash and the data flash select bit 1 on reads. Both local memory views select bit 2. `cacheable` is 1 only for accepted accesses to the cached flash and cached local memory windows.
- R9: An accepted write to any flash window selects bit 4 and never bit 1.
- R10: `pass` and `tgt_sel` follow the request in the same cycle. With `pass` at 1, `tgt_sel` has exactly one bit set. With `pass` at 0, `tgt_sel` and `cacheable` are zero. With `req_valid` at 0, `pass` is 0.
- R11: `err_resp` is 1 in the cycle after a request with `req_valid` 1 that was rejected, and 0 otherwise. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Access size code |
| req_burst | input | 1 | 1 = block transfer, 0 = single |
| req_write | input | 1 | 1 = write, 0 = read |
| dcache_en | input | 1 | Data cache currently enabled |
| pcache_en | input | 1 | Program cache currently enabled |
| dbg_en | input | 1 | On-chip debug enabled |
| tgt_sel | output | 5 | One-hot target select |
| pass | output | 1 | Request accepted and forwarded |
| cacheable | output | 1 | Accepted window is a cacheable view |
| err_resp | output | 1 | Bus error response, one cycle after rejection |

## Verification
On every cycle the bound checker enforces the rejection rules that need only the decoded window and the request fields. These are the lockouts for cache state, tag arrays and trace RAM, natural alignment and unmapped addresses. It also checks that flash writes never reach the read port, that the select is one-hot with `pass`, and that the error pulse lines up with the rejection that caused it. The mapping of each window to its target and its cacheable attribute, and the acceptance of legal accesses, only show up in the bench scenarios. The bench sweeps every window with offsets, sizes, burst, direction and all eight settings of the three enables. Reset behaviour and the one-cycle length of the error pulse are also shown only by the bench.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

    localparam int ADDR_W    = 32;
    localparam int N_REG     = 12;
    localparam int N_TGT     = 5;
    localparam int REG_IDX_W = $clog2(N_REG);

    typedef enum logic [2:0] {
        TGT_CPU_RAM   = 3'd0,
        TGT_FLASH_RD  = 3'd1,
        TGT_LMEM      = 3'd2,
        TGT_TRACE_RAM = 3'd3,
        TGT_FLASH_CMD = 3'd4
    } tgt_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } size_e;

    typedef struct packed {
        logic [31:0] base;
        logic [5:0]  span_log2;
        tgt_e        tgt;
        logic        cacheable;
        logic        flash;
        logic        dc_lock;
        logic        pc_lock;
        logic        tag_only;
        logic        dbg_only;
    } region_t;

    // Window indices used by the checker
    localparam int RID_DCACHE = 2;
    localparam int RID_DTAG   = 3;
    localparam int RID_PCACHE = 4;
    localparam int RID_PTAG   = 5;
    localparam int RID_TRACE  = 11;

    function automatic region_t region_entry(input int idx);
        region_t e;
        e = '0;
        e.tgt = TGT_CPU_RAM;
        case (idx)
            0:  begin e.base = 32'h7000_0000; e.span_log2 = 6'd16; end
            1:  begin e.base = 32'h7010_0000; e.span_log2 = 6'd16; end
            2:  begin e.base = 32'h7020_0000; e.span_log2 = 6'd14; e.dc_lock = 1'b1; end
            3:  begin e.base = 32'h7030_0000; e.span_log2 = 6'd12; e.dc_lock = 1'b1;
                      e.tag_only = 1'b1; end
            4:  begin e.base = 32'h7040_0000; e.span_log2 = 6'd14; e.pc_lock = 1'b1; end
            5:  begin e.base = 32'h7050_0000; e.span_log2 = 6'd12; e.pc_lock = 1'b1;
                      e.tag_only = 1'b1; end
            6:  begin e.base = 32'h8000_0000; e.span_log2 = 6'd24; e.tgt = TGT_FLASH_RD;
                      e.flash = 1'b1; e.cacheable = 1'b1; end
            7:  begin e.base = 32'hA000_0000; e.span_log2 = 6'd24; e.tgt = TGT_FLASH_RD;
                      e.flash = 1'b1; end
            8:  begin e.base = 32'hAF00_0000; e.span_log2 = 6'd24; e.tgt = TGT_FLASH_RD;
                      e.flash = 1'b1; end
            9:  begin e.base = 32'h9000_0000; e.span_log2 = 6'd20; e.tgt = TGT_LMEM;
                      e.cacheable = 1'b1; end
            10: begin e.base = 32'hB000_0000; e.span_log2 = 6'd20; e.tgt = TGT_LMEM; end
            11: begin e.base = 32'hF000_0000; e.span_log2 = 6'd12; e.tgt = TGT_TRACE_RAM;
                      e.dbg_only = 1'b1; end
            default: e = '0;
        endcase
        return e;
    endfunction

    function automatic logic misaligned(input logic [2:0] lo, input size_e sz);
        case (sz)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lo[0];
            SZ_WORD: return |lo[1:0];
            default: return |lo;
        endcase
    endfunction

endpackage

// File: rtl/mrg_decode.sv
module mrg_decode
    import mrg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = N_REG
) (
    input  logic [AW-1:0]          addr,
    output logic                   hit,
    output logic [$clog2(NR)-1:0]  idx,
    output region_t                attr
);
    localparam int IW = $clog2(NR);

    logic [NR-1:0] match;

    for (genvar g = 0; g < NR; g++) begin : g_win
        localparam region_t ENT = region_entry(g);
        logic [AW-1:0] mask;
        assign mask     = {AW{1'b1}} << ENT.span_log2;
        assign match[g] = ((addr ^ ENT.base[AW-1:0]) & mask) == '0;
    end

    // Lowest index wins if windows ever overlap
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = NR - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
        attr = region_entry(int'(idx));
    end

endmodule

// File: rtl/mrg_rules.sv
module mrg_rules
    import mrg_pkg::*;
#(
    parameter int NT = N_TGT
) (
    input  logic          req_valid,
    input  logic [2:0]    addr_lo,
    input  size_e         size,
    input  logic          burst,
    input  logic          write,
    input  logic          dcache_en,
    input  logic          pcache_en,
    input  logic          dbg_en,
    input  logic          hit,
    input  region_t       attr,
    output logic          allow,
    output logic [NT-1:0] sel,
    output logic          cacheable
);
    logic reject;
    tgt_e route;

    always_comb begin
        reject = !hit
              || misaligned(addr_lo, size)
              || (attr.dc_lock  && dcache_en)
              || (attr.pc_lock  && pcache_en)
              || (attr.tag_only && (burst || (addr_lo != 3'b000)))
              || (attr.dbg_only && !dbg_en);
        allow     = req_valid && !reject;
        route     = (attr.flash && write) ? TGT_FLASH_CMD : attr.tgt;
        sel       = allow ? (NT'(1) << route) : '0;
        cacheable = allow && attr.cacheable;
    end

endmodule

// File: rtl/mrg_resp.sv
module mrg_resp (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic allow,
    output logic err
);
    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= req_valid && !allow;
    end
endmodule

// File: rtl/mem_region_guard.sv
module mem_region_guard
    import mrg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NT = N_TGT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    input  logic          req_burst,
    input  logic          req_write,
    input  logic          dcache_en,
    input  logic          pcache_en,
    input  logic          dbg_en,
    output logic [NT-1:0] tgt_sel,
    output logic          pass,
    output logic          cacheable,
    output logic          err_resp
);
    logic                 hit;
    logic [REG_IDX_W-1:0] hit_idx;
    region_t              attr;

    mrg_decode #(.AW(AW), .NR(N_REG)) u_decode (
        .addr (req_addr),
        .hit  (hit),
        .idx  (hit_idx),
        .attr (attr)
    );

    mrg_rules #(.NT(NT)) u_rules (
        .req_valid (req_valid),
        .addr_lo   (req_addr[2:0]),
        .size      (size_e'(req_size)),
        .burst     (req_burst),
        .write     (req_write),
        .dcache_en (dcache_en),
        .pcache_en (pcache_en),
        .dbg_en    (dbg_en),
        .hit       (hit),
        .attr      (attr),
        .allow     (pass),
        .sel       (tgt_sel),
        .cacheable (cacheable)
    );

    mrg_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .allow     (pass),
        .err       (err_resp)
    );

endmodule

// File: rtl/mrg_checker.sv
module mrg_checker
    import mrg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [31:0]          req_addr,
    input logic [1:0]           req_size,
    input logic                 req_burst,
    input logic                 req_write,
    input logic                 dcache_en,
    input logic                 pcache_en,
    input logic                 dbg_en,
    input logic [N_TGT-1:0]     tgt_sel,
    input logic                 pass,
    input logic                 cacheable,
    input logic                 err_resp,
    input logic                 hit,
    input logic [REG_IDX_W-1:0] hit_idx
);
    logic in_dc, in_pc, in_tag, in_trace, bad_align;
    assign in_dc     = hit && (hit_idx == REG_IDX_W'(RID_DCACHE) || hit_idx == REG_IDX_W'(RID_DTAG));
    assign in_pc     = hit && (hit_idx == REG_IDX_W'(RID_PCACHE) || hit_idx == REG_IDX_W'(RID_PTAG));
    assign in_tag    = hit && (hit_idx == REG_IDX_W'(RID_DTAG) || hit_idx == REG_IDX_W'(RID_PTAG));
    assign in_trace  = hit && (hit_idx == REG_IDX_W'(RID_TRACE));
    assign bad_align = (req_size == 2'd1 && req_addr[0])
                    || (req_size == 2'd2 && req_addr[1:0] != 2'b00)
                    || (req_size == 2'd3 && req_addr[2:0] != 3'b000);

    a_r1_unmapped_blocked: assert property (@(posedge clk) disable iff (rst)
        !hit |-> !pass);
    a_r2_dcache_lock: assert property (@(posedge clk) disable iff (rst)
        (in_dc && dcache_en) |-> !pass);
    a_r3_pcache_lock: assert property (@(posedge clk) disable iff (rst)
        (in_pc && pcache_en) |-> !pass);
    a_r4_tag_single_aligned: assert property (@(posedge clk) disable iff (rst)
        (in_tag && (req_burst || req_addr[2:0] != 3'b000)) |-> !pass);
    a_r5_natural_align: assert property (@(posedge clk) disable iff (rst)
        bad_align |-> !pass);
    a_r6_trace_debug: assert property (@(posedge clk) disable iff (rst)
        (in_trace && !dbg_en) |-> !pass);
    a_r8_cacheable_needs_pass: assert property (@(posedge clk) disable iff (rst)
        cacheable |-> pass);
    a_r9_no_write_to_read_port: assert property (@(posedge clk) disable iff (rst)
        (pass && req_write) |-> !tgt_sel[1]);
    a_r10_onehot_select: assert property (@(posedge clk) disable iff (rst)
        pass |-> ($countones(tgt_sel) == 1));
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !pass |-> (tgt_sel == '0 && !cacheable));
    a_r10_valid_gate: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !pass);
    a_r11_err_follows_reject: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !pass) |=> err_resp);
    a_r11_err_only_on_reject: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || pass) |=> !err_resp);
endmodule

bind mem_region_guard mrg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_burst (req_burst),
    .req_write (req_write),
    .dcache_en (dcache_en),
    .pcache_en (pcache_en),
    .dbg_en    (dbg_en),
    .tgt_sel   (tgt_sel),
    .pass      (pass),
    .cacheable (cacheable),
    .err_resp  (err_resp),
    .hit       (hit),
    .hit_idx   (hit_idx)
);

// File: tb/mem_region_guard_test.sv
module mem_region_guard_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_burst = 1'b0;
    logic        req_write = 1'b0;
    logic        dcache_en = 1'b0;
    logic        pcache_en = 1'b0;
    logic        dbg_en = 1'b0;
    logic [4:0]  tgt_sel;
    logic        pass;
    logic        cacheable;
    logic        err_resp;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    mem_region_guard uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_burst(req_burst), .req_write(req_write),
        .dcache_en(dcache_en), .pcache_en(pcache_en), .dbg_en(dbg_en),
        .tgt_sel(tgt_sel), .pass(pass), .cacheable(cacheable), .err_resp(err_resp)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [1:0]  sz;
        logic        b, w, dc, pc, dbg;
        logic        ep, ec;
        logic [4:0]  et;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [0:NV-1] = '{
        '{32'h7000_0010, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00001, 4'd7},  // R7
        '{32'h7010_0003, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00001, 4'd7},  // R7
        '{32'h7000_0002, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd5},  // R5
        '{32'h7000_0006, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00001, 4'd5},  // R5
        '{32'h7000_0004, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd5},  // R5
        '{32'h7020_0008, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00001, 4'd2},  // R2
        '{32'h7020_0008, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd2},  // R2
        '{32'h7030_0010, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00001, 4'd4},  // R4
        '{32'h7030_0010, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd4},  // R4
        '{32'h7030_0014, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd4},  // R4
        '{32'h7040_0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd3},  // R3
        '{32'h7050_0008, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00001, 4'd3},  // R3
        '{32'h8000_1000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'b00010, 4'd8},  // R8
        '{32'hA000_1000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00010, 4'd8},  // R8
        '{32'hA000_1000, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b10000, 4'd9},  // R9
        '{32'hAF00_0020, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b10000, 4'd9},  // R9
        '{32'h9000_0040, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'b00100, 4'd8},  // R8
        '{32'hB000_0040, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'b00100, 4'd8},  // R8
        '{32'hF000_0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd6},  // R6
        '{32'hF000_0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'b01000, 4'd6},  // R6
        '{32'h6000_0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd1},  // R1
        '{32'h7060_0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd1},  // R1
        '{32'h8100_0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'b00000, 4'd1},  // R1
        '{32'h8000_0008, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'b10000, 4'd9}   // R9
    };

    // Sweep window bases; index 12 is an unmapped address (R1)
    localparam logic [31:0] BASES [0:12] = '{
        32'h7000_0000, 32'h7010_0000, 32'h7020_0000, 32'h7030_0000,
        32'h7040_0000, 32'h7050_0000, 32'h8000_0000, 32'hA000_0000,
        32'hAF00_0000, 32'h9000_0000, 32'hB000_0000, 32'hF000_0000,
        32'h6000_0000
    };
    localparam logic [31:0] OFFS [0:3] = '{32'd0, 32'd1, 32'd2, 32'd4};

    // Expected {pass, cacheable, tgt_sel} from the requirements
    function automatic logic [6:0] model(input int r, input logic [31:0] a, input logic [1:0] sz,
                                         input logic b, input logic w, input logic dc,
                                         input logic pc, input logic dbg);
        logic bad;
        logic [4:0] t;
        logic c;
        bad = (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00)
           || (sz == 2'd3 && a[2:0] != 3'b000);                    // R5
        if ((r == 2 || r == 3) && dc) bad = 1'b1;                    // R2
        if ((r == 4 || r == 5) && pc) bad = 1'b1;                    // R3
        if ((r == 3 || r == 5) && (b || a[2:0] != 3'b000)) bad = 1'b1; // R4
        if (r == 11 && !dbg) bad = 1'b1;                             // R6
        if (r == 12) bad = 1'b1;                                     // R1
        if (r <= 5)       t = 5'b00001;
        else if (r <= 8)  t = w ? 5'b10000 : 5'b00010;               // R8 R9
        else if (r <= 10) t = 5'b00100;
        else              t = 5'b01000;
        c = (r == 6 || r == 9);
        if (bad) return 7'b0;
        return {1'b1, c, t};
    endfunction

    function automatic string sweep_tag(input int r);
        if (r <= 1)  return "R7";
        if (r <= 3)  return "R2";
        if (r <= 5)  return "R3";
        if (r <= 10) return "R8";
        if (r == 11) return "R6";
        return "R1";
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [1:0] sz, input logic b,
                         input logic w, input logic dc, input logic pc, input logic dbg,
                         input logic [6:0] exp, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_burst = b; req_write = w;
        dcache_en = dc; pcache_en = pc; dbg_en = dbg;
        #1;
        check(req, $sformatf("verdict @%h sz%0d b%0d w%0d", a, sz, b, w),
              {25'd0, pass, cacheable, tgt_sel}, {25'd0, exp});
        @(posedge clk);
        #1;
        check("R11", $sformatf("err after @%h", a), {31'd0, err_resp}, {31'd0, ~exp[6]});
    endtask

    task automatic report;
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        report();
        $finish;
    end

    initial begin
        // Reset state (R11, R10)
        repeat (2) @(posedge clk);
        #1;
        check("R11", "err in reset", {31'd0, err_resp}, 32'd0);
        check("R10", "idle pass/select", {26'd0, pass, tgt_sel}, 32'd0);

        // Rejected request held during reset must not raise err (R11)
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h6000_0000; req_size = 2'd2;
        @(posedge clk);
        #1;
        check("R11", "err with reset held", {31'd0, err_resp}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b0;

        // Directed table
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].a, VECS[i].sz, VECS[i].b, VECS[i].w, VECS[i].dc, VECS[i].pc,
                  VECS[i].dbg, {VECS[i].ep, VECS[i].ec, VECS[i].et},
                  $sformatf("R%0d", VECS[i].rq));
        end

        // Full sweep: windows x offsets x sizes x burst x direction x enables
        for (int r = 0; r < 13; r++)
            for (int o = 0; o < 4; o++)
                for (int s = 0; s < 4; s++)
                    for (int bw = 0; bw < 4; bw++)
                        for (int cfg = 0; cfg < 8; cfg++) begin
                            logic [31:0] a;
                            a = BASES[r] + OFFS[o];
                            apply(a, s[1:0], bw[1], bw[0], cfg[0], cfg[1], cfg[2],
                                  model(r, a, s[1:0], bw[1], bw[0], cfg[0], cfg[1], cfg[2]),
                                  sweep_tag(r));
                        end

        // Error pulse lasts one cycle after a lone reject (R11)
        apply(32'h6000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, "R1");
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R11", "err drops after idle", {31'd0, err_resp}, 32'd0);

        // Back-to-back rejects hold err for two cycles (R11)
        apply(32'h6000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, "R1");
        apply(32'hF000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd0, "R6");

        // Valid low on an otherwise legal request: nothing selected, no err (R10)
        @(negedge clk);
        req_valid = 1'b0; req_addr = 32'h7000_0000; req_size = 2'd0;
        #1;
        check("R10", "valid low verdict", {25'd0, pass, cacheable, tgt_sel}, 32'd0);
        @(posedge clk);
        #1;
        check("R11", "valid low err", {31'd0, err_resp}, 32'd0);

        report();
        $finish;
    end

endmodule